// File: doc/BRIEF.md
# Local Interrupt Timer with Vector Table Entry

This block is a down-counting timer that raises an interrupt request when it runs out. Its behaviour on expiry comes from a packed 32-bit vector table entry: the entry selects the interrupt vector, the delivery mode and the trigger mode, whether the request is suppressed, and whether the timer restarts by itself. Software writes the entry and an initial-count value through a single-cycle register-write port, and reads the entry and the live count back on dedicated outputs.

The counter moves down by one on every cycle in which `tick_en` is high. A tick while the count is one is an expiry. On an expiry the block raises a one-cycle request that carries the entry's fields, unless the entry is masked. In periodic mode the counter then restarts from the initial count. In one-shot mode it rests at zero. Prescaling of the tick, delivery of the request to a remote target and address decoding all belong to the surrounding logic.

Top module: `lvt_timer`

## Requirements
- R1: After reset, `entry_rd` reads 0x0001_0000 (masked, one-shot, vector 0), `count_rd` reads 0 and `irq_valid` is low.
- R2: A write with `wr_addr`=0 stores the entry. Bits 7:0 hold the vector, bits 10:8 the delivery mode, bit 13 the polarity, bit 15 the trigger (1 = level), bit 16 the mask and bit 17 the periodic select. Every other bit, including the read-only status bits 12 and 14, reads as zero. Writing all ones therefore reads back 0x0003_A7FF.
- R3: A write with `wr_addr`=1 stores the initial count and loads it into the counter. `count_rd` shows the value on the cycle after the write.
- R4: The count drops by exactly one per cycle with `tick_en` high and holds while `tick_en` is low.
- R5: A tick while the count is 1 is an expiry. If the entry is unmasked, `irq_valid` is high for one cycle on the following cycle, with `irq_vector`, `irq_mode` and `irq_level` equal to entry bits 7:0, 10:8 and 15.
- R6: An expiry while entry bit 16 is set produces no request.
- R7: With entry bit 17 set, an expiry reloads the counter from the initial count, whether or not the entry is masked.
- R8: With entry bit 17 clear, the counter stays at zero after an expiry until the initial count is written again.
- R9: Writing an initial count of zero stops the timer. No expiry and no request follow.
- R10: A write to the initial count in the same cycle as a tick takes precedence. The counter loads the new value, and no decrement or expiry occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Decrement enable, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = vector table entry, 1 = initial count |
| wr_data | input | 32 | Write data |
| entry_rd | output | 32 | Entry readback, unimplemented bits zero |
| count_rd | output | COUNT_W | Current count |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |
| irq_mode | output | 3 | Delivery mode of the request |
| irq_level | output | 1 | Trigger mode of the request, 1 = level |

## Verification
The hardest case to reach from the ports is a write to the initial count that arrives in exactly the same cycle as the tick that would expire the timer. The bench counts ticks from a known load, so it drives the new count on the precise cycle in which the count reads one. A second hard case is a periodic reload that is also masked, where the only visible evidence is the count sequence. The bench samples `count_rd` every cycle and matches it against the expected pattern while the scoreboard flags any request that appears.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
   localparam int unsigned ENTRY_W = 32;
   localparam int unsigned VEC_LSB = 0;
   localparam int unsigned MODE_LSB = 8;
   localparam int unsigned POL_BIT = 13;
   localparam int unsigned TRIG_BIT = 15;
   localparam int unsigned MASK_BIT = 16;
   localparam int unsigned PER_BIT = 17;
   localparam logic [ENTRY_W-1:0] ENTRY_WMASK = 32'h0003_A7FF;
   localparam logic [ENTRY_W-1:0] ENTRY_RESET = 32'h0001_0000;

   typedef struct packed {
      logic       periodic;
      logic       masked;
      logic       level;
      logic [2:0] mode;
      logic [7:0] vector;
   } lvt_cfg_t;
endpackage

// File: rtl/lvt_entry_reg.sv
module lvt_entry_reg
   import lvt_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ENTRY_W-1:0] wdata,
   output logic [ENTRY_W-1:0] entry_q,
   output lvt_cfg_t           cfg
);
   // one flop per implemented bit, constant zero elsewhere
   for (genvar b = 0; b < ENTRY_W; b++) begin : g_bit
      if (ENTRY_WMASK[b]) begin : g_flop
         always_ff @(posedge clk) begin
            if (!rst_n)     entry_q[b] <= ENTRY_RESET[b];
            else if (wr_en) entry_q[b] <= wdata[b];
         end
      end else begin : g_zero
         assign entry_q[b] = 1'b0;
      end
   end

   wire unused_wbits = ^(wdata & ~ENTRY_WMASK);

   always_comb begin
      cfg.vector   = entry_q[VEC_LSB +: 8];
      cfg.mode     = entry_q[MODE_LSB +: 3];
      cfg.level    = entry_q[TRIG_BIT];
      cfg.masked   = entry_q[MASK_BIT];
      cfg.periodic = entry_q[PER_BIT];
   end
endmodule

// File: rtl/lvt_down_counter.sv
module lvt_down_counter #(
   parameter int unsigned COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [COUNT_W-1:0] load_val,
   input  logic               tick,
   input  logic               periodic,
   output logic [COUNT_W-1:0] count,
   output logic               expire
);
   localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

   logic [COUNT_W-1:0] reload_q;

   // a load in the same cycle as a tick wins
   assign expire = !load && tick && (count == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         count    <= '0;
      end else if (load) begin
         reload_q <= load_val;
         count    <= load_val;
      end else if (expire) begin
         count <= periodic ? reload_q : '0;
      end else if (tick && count != '0) begin
         count <= count - ONE;
      end
   end
endmodule

// File: rtl/lvt_irq_out.sv
module lvt_irq_out
   import lvt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  lvt_cfg_t   cfg,
   output logic       irq_valid,
   output logic [7:0] irq_vector,
   output logic [2:0] irq_mode,
   output logic       irq_level
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_vector <= '0;
         irq_mode   <= '0;
         irq_level  <= 1'b0;
      end else begin
         irq_valid <= expire && !cfg.masked;
         if (expire) begin
            irq_vector <= cfg.vector;
            irq_mode   <= cfg.mode;
            irq_level  <= cfg.level;
         end
      end
   end
endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
   import lvt_pkg::*;
#(
   parameter int unsigned COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic               wr_en,
   input  logic               wr_addr,
   input  logic [31:0]        wr_data,
   output logic [31:0]        entry_rd,
   output logic [COUNT_W-1:0] count_rd,
   output logic               irq_valid,
   output logic [7:0]         irq_vector,
   output logic [2:0]         irq_mode,
   output logic               irq_level
);
   if (COUNT_W < 2 || COUNT_W > 32) begin : g_bad_width
      $error("lvt_timer: COUNT_W must lie in 2..32");
   end

   lvt_cfg_t cfg;
   logic     expire;
   logic     wr_entry, wr_count;
   logic [COUNT_W-1:0] load_val;

   assign wr_entry = wr_en && !wr_addr;
   assign wr_count = wr_en && wr_addr;

   if (COUNT_W == 32) begin : g_full
      assign load_val = wr_data;
   end else begin : g_narrow
      assign load_val = wr_data[COUNT_W-1:0];
      wire unused_hi = ^wr_data[31:COUNT_W];
   end

   lvt_entry_reg u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_entry),
      .wdata   (wr_data),
      .entry_q (entry_rd),
      .cfg     (cfg)
   );

   lvt_down_counter #(.COUNT_W(COUNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_count),
      .load_val (load_val),
      .tick     (tick_en),
      .periodic (cfg.periodic),
      .count    (count_rd),
      .expire   (expire)
   );

   lvt_irq_out u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire     (expire),
      .cfg        (cfg),
      .irq_valid  (irq_valid),
      .irq_vector (irq_vector),
      .irq_mode   (irq_mode),
      .irq_level  (irq_level)
   );
endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk #(
   parameter int unsigned COUNT_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick_en,
   input logic               wr_en,
   input logic               wr_addr,
   input logic [31:0]        wr_data,
   input logic [31:0]        entry_rd,
   input logic [COUNT_W-1:0] count_rd,
   input logic               irq_valid,
   input logic [7:0]         irq_vector,
   input logic [2:0]         irq_mode,
   input logic               irq_level
);
   localparam logic [31:0] KEEP = 32'h0003_A7FF;

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_rd & ~KEEP) == 32'h0);

   assert_load_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr) |=> count_rd == $past(wr_data[COUNT_W-1:0]));

   assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !(wr_en && wr_addr)) |=> $stable(count_rd));

   assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> ($past(count_rd) == COUNT_W'(1)) && $past(tick_en)
                    && !$past(wr_en && wr_addr));

   assert_irq_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_vector == $past(entry_rd[7:0]))
                    && (irq_mode == $past(entry_rd[10:8]))
                    && (irq_level == $past(entry_rd[15])));

   assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> !$past(entry_rd[16]));

   assert_zero_rests_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (count_rd == '0 && !(wr_en && wr_addr)) |=> count_rd == '0);
endmodule

bind lvt_timer lvt_timer_chk #(.COUNT_W(COUNT_W)) u_lvt_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .entry_rd   (entry_rd),
   .count_rd   (count_rd),
   .irq_valid  (irq_valid),
   .irq_vector (irq_vector),
   .irq_mode   (irq_mode),
   .irq_level  (irq_level)
);

// File: tb/tb_lvt_timer.sv
module tb_lvt_timer;
   localparam int CW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_addr = 1'b0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   entry_rd;
   logic [CW-1:0] count_rd;
   logic          irq_valid;
   logic [7:0]    irq_vector;
   logic [2:0]    irq_mode;
   logic          irq_level;

   int n_cmp = 0;
   int n_bad = 0;
   logic [11:0] exp_q[$];   // {level, mode, vector}

   always #5 clk = ~clk;

   lvt_timer #(.COUNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .entry_rd(entry_rd),
      .count_rd(count_rd), .irq_valid(irq_valid), .irq_vector(irq_vector),
      .irq_mode(irq_mode), .irq_level(irq_level)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: every request must match the head of the queue
   always @(negedge clk) begin
      if (rst_n && irq_valid) begin
         if (exp_q.size() == 0) begin
            check("R6/R9 unexpected request", {20'h0, irq_level, irq_mode, irq_vector}, 32'hFFFF_FFFF);
         end else begin
            check("R5 request fields", {20'h0, irq_level, irq_mode, irq_vector}, {20'h0, exp_q.pop_front()});
         end
      end
   end

   task automatic write_reg(input logic a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_irq(input logic [31:0] entry);
      exp_q.push_back({entry[15], entry[10:8], entry[7:0]});
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      wait_cycles(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 entry reset", entry_rd, 32'h0001_0000);
      check("R1 count reset", count_rd, 32'h0);
      check("R1 no request", {31'h0, irq_valid}, 32'h0);

      // R2 implemented bits only
      write_reg(1'b0, 32'hFFFF_FFFF);
      check("R2 entry all ones", entry_rd, 32'h0003_A7FF);

      // R4 hold without ticks
      write_reg(1'b1, 32'd9);
      check("R3 load", count_rd, 32'd9);
      wait_cycles(4);
      check("R4 hold", count_rd, 32'd9);

      // R5/R8 one-shot unmasked, level, mode 2, vector 0x41
      write_reg(1'b0, 32'h0000_8241);
      check("R2 entry fields", entry_rd, 32'h0000_8241);
      tick_en = 1'b1;
      expect_irq(32'h0000_8241);
      write_reg(1'b1, 32'd3);
      check("R3 load with tick", count_rd, 32'd3);
      @(negedge clk); check("R4 decrement", count_rd, 32'd2);
      @(negedge clk); check("R4 decrement", count_rd, 32'd1);
      @(negedge clk); check("R8 zero after expiry", count_rd, 32'd0);
      wait_cycles(5);
      check("R8 stays zero", count_rd, 32'd0);
      check("R5 request delivered", exp_q.size(), 32'd0);
      tick_en = 1'b0;

      // R6/R7 masked periodic: count wraps, no request
      write_reg(1'b0, 32'h0003_0022);
      tick_en = 1'b1;
      write_reg(1'b1, 32'd2);
      for (int k = 0; k < 6; k++) begin
         check("R7 masked reload sequence", count_rd, (k % 2 == 0) ? 32'd2 : 32'd1);
         @(negedge clk);
      end
      tick_en = 1'b0;

      // R7 periodic unmasked, edge mode 5, gated ticks
      write_reg(1'b0, 32'h0002_0577);
      write_reg(1'b1, 32'd4);
      expect_irq(32'h0002_0577);
      expect_irq(32'h0002_0577);
      for (int k = 0; k < 16; k++) begin
         tick_en = (k % 2 == 0);
         @(negedge clk);
      end
      tick_en = 1'b0;
      wait_cycles(2);
      check("R7 reload after two periods", count_rd, 32'd4);
      check("R7 two requests", exp_q.size(), 32'd0);

      // R9 writing zero stops
      write_reg(1'b0, 32'h0000_0010);
      tick_en = 1'b1;
      write_reg(1'b1, 32'd5);
      wait_cycles(2);
      write_reg(1'b1, 32'd0);
      wait_cycles(10);
      check("R9 stopped", count_rd, 32'd0);

      // R10 load wins over expiring tick
      write_reg(1'b1, 32'd3);
      @(negedge clk);
      @(negedge clk);
      check("R10 count at one", count_rd, 32'd1);
      wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'd7;
      @(negedge clk);
      wr_en = 1'b0;
      tick_en = 1'b0;
      check("R10 load wins", count_rd, 32'd7);
      wait_cycles(3);
      check("R10 no request", exp_q.size(), 32'd0);
      check("R10 count held", count_rd, 32'd7);

      finish_run();
   end
endmodule